// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Stop Lockout

This block is a supervision timer that asks for a chip reset when software stops servicing it. Two 8-bit down counters form a 16-bit chain. A low stage is clocked by a divide-by-16 prescaler. A high stage is clocked either by the low stage's wrap pulses or by the prescaler directly, depending on a control bit. When the high stage wraps past zero, the block raises a reset request and holds it until the block itself is reset.

Software reaches the block through one 8-bit control register. Any write restarts the countdown from the full count, and the first write after reset also starts the timer. A read returns the two control bits and the top six bits of the live high-stage count. A lock bit can be set once. While it is set, executing the stop-mode instruction triggers the same reset request as a timeout.

Top module: `wdog_cascade`

## Requirements
- R1: After reset, and until the first register write, neither stage counts: `wdt_rst_req` stays 0 and a read returns 0x3F.
- R2: Any write, whatever its data, starts counting, clears the prescaler and reloads both stages to 0xFF.
- R3: With source bit 7 = 1, the high stage steps down once every 16 clocks. `wdt_rst_req` rises exactly 4096 clock edges after the write edge.
- R4: With source bit 7 = 0, the high stage steps down once per low-stage wrap, which is once every 4096 clocks. The timeout is 2^20 clocks times PRE_DIV/16.
- R5: A read strobe captures {bit 7 source select, bit 6 stop lock, high count bits 7..2} into `rd_data`. The value appears after the next clock edge.
- R6: Bit 6 (stop lock) is set by writing 1. Writing 0 later does not clear it; only reset clears it.
- R7: `stop_exec` while the stop lock is 1 raises `wdt_rst_req` at the next edge. While the lock is 0, `stop_exec` is ignored.
- R8: `wdt_rst_req` is registered and stays at 1 until reset. Reset clears it, clears both control bits and returns the block to the idle state.
- R9: When a write and a prescaler tick fall in the same cycle, the write wins and the counters reload. The new control bits act from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| reg_wr | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data (bit 7 source select, bit 6 stop lock) |
| reg_rd | input | 1 | Control register read strobe |
| rd_data | output | 8 | Captured read value |
| stop_exec | input | 1 | One-cycle strobe: stop-mode instruction executed |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
The timeout is driven with each high-stage source selected. With the prescaled source, the request edge lands exactly on clock 4096. With the cascaded source, a mid-count readback gives a step rate 256 times slower, and a faster-prescaler instance is run to the full 2^16-tick limit. A restart write placed on the exact cycle of a prescaler tick separates "write wins" from "tick wins", because losing the tick would bring the request 16 clocks early. The stop strobe is applied with the lock clear, set, and after an attempted clear, which distinguishes an ignored strobe, a working lock and a lock that software could undo.

// File: rtl/wdog_cascade_pkg.sv
package wdog_cascade_pkg;
  // wrapping down-step of a stage counter
  function automatic logic [7:0] step_down(input logic [7:0] v);
    return v - 8'd1;
  endfunction

  // read image of the control register
  function automatic logic [7:0] pack_status(input logic src_sel, input logic lock,
                                             input logic [5:0] hi_top);
    return {src_sel, lock, hi_top};
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  assign tick = run && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (run)      cnt <= (cnt == LAST) ? '0 : cnt + PW'(1);
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         uf
);
  import wdog_cascade_pkg::*;

  assign uf = dec && !load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '1;
    else if (load)  cnt <= '1;
    else if (dec)   cnt <= W'(step_down(8'(cnt)));
  end
endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade #(
  parameter int PRE_DIV = 16,
  parameter int STAGE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] wr_data,
  input  logic       reg_rd,
  output logic [7:0] rd_data,
  input  logic       stop_exec,
  output logic       wdt_rst_req
);
  import wdog_cascade_pkg::*;

  localparam int SEL_BIT  = 7;
  localparam int LOCK_BIT = 6;

  logic               running;
  logic               src_sel;
  logic               stp_dis;
  logic               tick;
  logic               lo_uf;
  logic               hi_uf;
  logic               hi_en;
  logic [STAGE_W-1:0] lo_cnt;
  logic [STAGE_W-1:0] hi_cnt;
  logic               req_q;

  wdog_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(reg_wr), .run(running), .tick(tick)
  );

  wdog_stage #(.W(STAGE_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .load(reg_wr), .dec(tick), .cnt(lo_cnt), .uf(lo_uf)
  );

  assign hi_en = src_sel ? tick : lo_uf;

  wdog_stage #(.W(STAGE_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .load(reg_wr), .dec(hi_en), .cnt(hi_cnt), .uf(hi_uf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      src_sel <= 1'b0;
      stp_dis <= 1'b0;
    end else if (reg_wr) begin
      running <= 1'b1;
      src_sel <= wr_data[SEL_BIT];
      stp_dis <= stp_dis | wr_data[LOCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              req_q <= 1'b0;
    else if (hi_uf || (stop_exec && stp_dis)) req_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= 8'h00;
    else if (reg_rd) rd_data <= pack_status(src_sel, stp_dis, 6'(hi_cnt[STAGE_W-1 -: 6]));
  end

  assign wdt_rst_req = req_q;
endmodule

// File: rtl/wdog_cascade_chk.sv
module wdog_cascade_chk #(
  parameter int STAGE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               stop_exec,
  input logic               running,
  input logic               stp_dis,
  input logic               hi_uf,
  input logic               lo_uf,
  input logic [STAGE_W-1:0] lo_cnt,
  input logic [STAGE_W-1:0] hi_cnt,
  input logic               wdt_rst_req
);
  AST_IDLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (lo_cnt == '1 && hi_cnt == '1 && !wdt_rst_req)); // R1
  AST_WR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (lo_cnt == '1 && hi_cnt == '1)); // R2
  AST_UF_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hi_uf |=> wdt_rst_req); // R3
  AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_uf && !reg_wr) |=> (lo_cnt == '1)); // R4
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stp_dis |=> stp_dis); // R6
  AST_STOP_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_exec && stp_dis) |=> wdt_rst_req); // R7
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> wdt_rst_req); // R8
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req) |-> $past(hi_uf || (stop_exec && stp_dis))); // R8
endmodule

bind wdog_cascade wdog_cascade_chk #(.STAGE_W(STAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .stop_exec(stop_exec),
  .running(running), .stp_dis(stp_dis), .hi_uf(hi_uf), .lo_uf(lo_uf),
  .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .wdt_rst_req(wdt_rst_req)
);

// File: tb/wdog_cascade_test.sv
module wdog_cascade_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       reg_rd = 1'b0;
  logic       stop_exec = 1'b0;
  logic [7:0] rd_data, rd_data_f;
  logic       wdt_rst_req, req_f;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_cascade uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_data(wr_data), .reg_rd(reg_rd),
    .rd_data(rd_data), .stop_exec(stop_exec), .wdt_rst_req(wdt_rst_req)
  );

  // faster prescaler copy, used only to reach the cascaded-source timeout
  wdog_cascade #(.PRE_DIV(2)) uut_fast (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_data(wr_data), .reg_rd(reg_rd),
    .rd_data(rd_data_f), .stop_exec(stop_exec), .wdt_rst_req(req_f)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; wr_data = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_exec = 1'b1;
    @(negedge clk); stop_exec = 1'b0;
  endtask

  // timeout edge: low at edge n-1 after write, high at edge n
  task automatic expect_timeout(input int n, input string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk); check(wdt_rst_req == 1'b0, tag, wdt_rst_req, 0);
    @(posedge clk);
    @(negedge clk); check(wdt_rst_req == 1'b1, tag, wdt_rst_req, 1);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    do_reset();
    check(wdt_rst_req == 1'b0, "R1 req after reset", wdt_rst_req, 0);
    do_read(v); check(v == 8'h3F, "R1 read after reset", v, 8'h3F);
    repeat (5000) @(posedge clk);
    @(negedge clk);
    check(wdt_rst_req == 1'b0, "R1 no count while idle", wdt_rst_req, 0);
    do_read(v); check(v == 8'h3F, "R1 count frozen while idle", v, 8'h3F);
  endtask

  task automatic t_fast_timeout();
    do_reset();
    do_write(8'h80);
    expect_timeout(4096, "R3 prescaled-source timeout");
    repeat (100) @(posedge clk);
    @(negedge clk); check(wdt_rst_req == 1'b1, "R8 request held", wdt_rst_req, 1);
    do_reset();
    check(wdt_rst_req == 1'b0, "R8 reset clears request", wdt_rst_req, 0);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    do_reset();
    do_write(8'h95);              // bit7=1, bit6=0, other bits ignored
    repeat (640) @(posedge clk);  // 40 steps: high = 0xD7
    do_read(v); check(v == 8'hB5, "R5 live high count readback", v, 8'hB5);
    do_write(8'h95);
    do_read(v); check(v == 8'hBF, "R2 write reloads stages", v, 8'hBF);
  endtask

  task automatic t_write_wins();
    do_reset();
    do_write(8'h80);
    repeat (15) @(posedge clk);   // next write edge coincides with a tick
    do_write(8'h80);
    expect_timeout(4096, "R9 write beats tick");
  endtask

  task automatic t_cascade_rate();
    logic [7:0] v;
    do_reset();
    do_write(8'h80);
    do_write(8'h00);              // source change takes effect next cycle
    repeat (4 * 4096) @(posedge clk);  // 4 low-stage wraps: high = 0xFB
    do_read(v); check(v == 8'h3E, "R4 cascaded step rate", v, 8'h3E);
    check(wdt_rst_req == 1'b0, "R9 new source in force", wdt_rst_req, 0);
  endtask

  task automatic t_cascade_timeout();
    do_reset();
    do_write(8'h00);
    repeat (131071) @(posedge clk);
    @(negedge clk); check(req_f == 1'b0, "R4 cascaded timeout early", req_f, 0);
    @(posedge clk);
    @(negedge clk); check(req_f == 1'b1, "R4 cascaded timeout edge", req_f, 1);
  endtask

  task automatic t_stop_lock();
    logic [7:0] v;
    do_reset();
    pulse_stop();
    check(wdt_rst_req == 1'b0, "R7 stop ignored idle unlocked", wdt_rst_req, 0);
    do_write(8'h00);
    pulse_stop();
    check(wdt_rst_req == 1'b0, "R7 stop ignored unlocked", wdt_rst_req, 0);
    do_write(8'h40);
    do_read(v); check(v == 8'h7F, "R6 lock set", v, 8'h7F);
    do_write(8'h00);
    do_read(v); check(v == 8'h7F, "R6 lock not clearable", v, 8'h7F);
    pulse_stop();
    check(wdt_rst_req == 1'b1, "R7 stop with lock resets", wdt_rst_req, 1);
    do_reset();
    do_read(v); check(v == 8'h3F, "R8 reset clears lock", v, 8'h3F);
  endtask

  initial begin
    t_idle();
    t_fast_timeout();
    t_readback();
    t_write_wins();
    t_cascade_rate();
    t_cascade_timeout();
    t_stop_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule